// File: doc/BRIEF.md
# Eight-Pin Port with Per-Pin Alternate Functions

This block is an eight-pin general-purpose I/O port. Every pin can act as a plain port bit or take on one fixed dedicated role tied to a neighbouring peripheral. Pins 0 and 2 carry serial transmit data out, and their inputs also feed 8-bit timer clocks. Pins 1 and 3 carry serial receive data in, or drive an 8-bit timer output. Pins 4 and 5 feed 16-bit timer clocks and external interrupt requests. Pin 6 drives a 16-bit timer flip-flop output. Pin 7 is an external interrupt input that can also wake the chip from a stop state.

Software controls the port through four 8-bit registers on a small strobe bus. The registers are an output latch, a direction mask, a function mask and an open-drain mask. The open-drain mask is backed only for pins 0 and 2. Pad inputs pass through a two-stage synchronizer before they reach software reads or any peripheral-side output. The pad output and output-enable are combinational from the register state and the peripheral inputs.

Top module: `pinmux_port`

## Requirements
- R1: After reset the output latch holds 8'hFF, and the direction, function and open-drain registers hold 0. As a result `pad_oe` is 0 and `pad_out` is 8'hFF.
- R2: Register addresses are 0 = data latch, 1 = direction, 2 = function and 3 = open-drain. A write with `bus_wr` is visible from the next clock edge. `bus_rdata` is loaded at the clock edge where `bus_rd` is high, takes the value from before any same-cycle write, and holds its value when `bus_rd` is low.
- R3: For a pin that is not in open-drain mode, `pad_oe[i]` equals direction bit i. `pad_out[i]` is the peripheral signal when function bit i is 1 and pin i has an output role (pins 0, 1, 2, 3 and 6); otherwise it is latch bit i.
- R4: Only bits 0 and 2 of the open-drain register are stored; the other bits read 0 and ignore writes. When open-drain bit i and direction bit i are both 1, `pad_out[i]` is 0 and `pad_oe[i]` is the inverse of the selected drive source.
- R5: A pad input change reaches every synchronized use after exactly two clock edges.
- R6: A read of address 0 returns the latch bit for pins whose direction bit is 1, and the synchronized pad level for the other pins.
- R7: `ser_rxd[0]` and `ser_rxd[1]` follow synchronized pins 1 and 3 when that pin's function bit is 1 and its direction bit is 0. Otherwise they stay at idle level 1.
- R8: `tmr8_clk[0]` and `tmr8_clk[1]` always follow synchronized pins 0 and 2.
- R9: `tmr16_clk[k]` and `ext_irq[k]` for k = 0, 1 follow synchronized pin 4+k when that pin's function bit is 1. Otherwise they are 0.
- R10: `ext_irq[2]` follows synchronized pin 7 when function bit 7 is 1, and is 0 otherwise. `wake_req` follows synchronized pin 7 when function bit 7 is 1 or `drv_en` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| ser_txd | input | 2 | Serial transmit data for pins 0 and 2 |
| tmr8_out | input | 2 | 8-bit timer outputs for pins 1 and 3 |
| tmr16_ff | input | 1 | 16-bit timer flip-flop output for pin 6 |
| drv_en | input | 1 | Global drive-enable control for wake qualification |
| ser_rxd | output | 2 | Serial receive from pins 1 and 3 |
| tmr8_clk | output | 2 | 8-bit timer clocks from pins 0 and 2 |
| tmr16_clk | output | 2 | 16-bit timer clocks from pins 4 and 5 |
| ext_irq | output | 3 | Interrupt requests from pins 4, 5 and 7 |
| wake_req | output | 1 | Stop-state wake request from pin 7 |

## Verification
There are three latencies. Pad outputs and enables respond in the same cycle to register state and peripheral inputs. Register writes and read data appear one edge after the strobe. Pad inputs reach reads and peripheral outputs two edges after they change. The bench drives every input 2 ns after a rising edge and updates its reference model at each rising edge. It compares every output at the falling edge, so each result is sampled in the cycle where it is due. Directed reads check the reset values and the open-drain mask, and a long randomized phase checks all mode combinations every cycle.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int PINS    = 8;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LATCH = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_FUNC  = 2'd2,
        SEL_OPEN  = 2'd3
    } reg_sel_e;

    // pins with a peripheral drive source, and pins with open-drain capability
    localparam logic [PINS-1:0] ALT_OUT_MASK = 8'b0100_1111;
    localparam logic [PINS-1:0] OPEN_MASK    = 8'b0000_0101;

    typedef struct packed {
        logic [PINS-1:0] latch;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] func;
        logic [PINS-1:0] open;
        logic [PINS-1:0] rdata;
    } port_regs_t;

    localparam port_regs_t REGS_RESET = '{
        latch: {PINS{1'b1}},
        dir:   '0,
        func:  '0,
        open:  '0,
        rdata: '0
    };
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= stg_d[k];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [PINS-1:0]   wdata,
    input  logic [PINS-1:0]   pin_sync,
    output logic [PINS-1:0]   latch,
    output logic [PINS-1:0]   dir,
    output logic [PINS-1:0]   func,
    output logic [PINS-1:0]   open,
    output logic [PINS-1:0]   rdata
);
    port_regs_t st_d, st_q;
    reg_sel_e   sel;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        st_d = st_q;
        if (rd) begin
            unique case (sel)
                SEL_LATCH: st_d.rdata = (st_q.latch & st_q.dir) | (pin_sync & ~st_q.dir);
                SEL_DIR:   st_d.rdata = st_q.dir;
                SEL_FUNC:  st_d.rdata = st_q.func;
                SEL_OPEN:  st_d.rdata = st_q.open;
                default:   st_d.rdata = '0;
            endcase
        end
        if (wr) begin
            unique case (sel)
                SEL_LATCH: st_d.latch = wdata;
                SEL_DIR:   st_d.dir   = wdata;
                SEL_FUNC:  st_d.func  = wdata;
                SEL_OPEN:  st_d.open  = wdata & OPEN_MASK;
                default:   st_d.latch = st_q.latch;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REGS_RESET;
        else        st_q <= st_d;
    end

    assign latch = st_q.latch;
    assign dir   = st_q.dir;
    assign func  = st_q.func;
    assign open  = st_q.open;
    assign rdata = st_q.rdata;
endmodule

// File: rtl/pinmux_drive.sv
module pinmux_drive #(
    parameter bit HAS_ALT = 1'b0,
    parameter bit HAS_OPEN = 1'b0
) (
    input  logic latch,
    input  logic dir,
    input  logic func,
    input  logic open,
    input  logic alt,
    output logic pad_out,
    output logic pad_oe
);
    logic src;
    logic od_on;

    always_comb begin
        src   = (HAS_ALT && func) ? alt : latch;
        od_on = HAS_OPEN ? (open & dir) : 1'b0;
        if (od_on) begin
            pad_out = 1'b0;
            pad_oe  = ~src;
        end else begin
            pad_out = src;
            pad_oe  = dir;
        end
    end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
    import pinmux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  pad_in,
    output logic [7:0]  pad_out,
    output logic [7:0]  pad_oe,
    input  logic [1:0]  ser_txd,
    input  logic [1:0]  tmr8_out,
    input  logic        tmr16_ff,
    input  logic        drv_en,
    output logic [1:0]  ser_rxd,
    output logic [1:0]  tmr8_clk,
    output logic [1:0]  tmr16_clk,
    output logic [2:0]  ext_irq,
    output logic        wake_req
);
    logic [PINS-1:0] latch_q, dir_q, func_q, open_q;
    logic [PINS-1:0] pin_s;
    logic [PINS-1:0] alt_src;

    pinmux_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pin_s)
    );

    pinmux_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .pin_sync(pin_s),
        .latch   (latch_q),
        .dir     (dir_q),
        .func    (func_q),
        .open    (open_q),
        .rdata   (bus_rdata)
    );

    always_comb begin
        alt_src    = '0;
        alt_src[0] = ser_txd[0];
        alt_src[1] = tmr8_out[0];
        alt_src[2] = ser_txd[1];
        alt_src[3] = tmr8_out[1];
        alt_src[6] = tmr16_ff;
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pinmux_drive #(
            .HAS_ALT (ALT_OUT_MASK[i]),
            .HAS_OPEN(OPEN_MASK[i])
        ) u_drv (
            .latch  (latch_q[i]),
            .dir    (dir_q[i]),
            .func   (func_q[i]),
            .open   (open_q[i]),
            .alt    (alt_src[i]),
            .pad_out(pad_out[i]),
            .pad_oe (pad_oe[i])
        );
    end

    always_comb begin
        ser_rxd[0]   = (func_q[1] & ~dir_q[1]) ? pin_s[1] : 1'b1;
        ser_rxd[1]   = (func_q[3] & ~dir_q[3]) ? pin_s[3] : 1'b1;
        tmr8_clk     = {pin_s[2], pin_s[0]};
        tmr16_clk[0] = func_q[4] & pin_s[4];
        tmr16_clk[1] = func_q[5] & pin_s[5];
        ext_irq[0]   = func_q[4] & pin_s[4];
        ext_irq[1]   = func_q[5] & pin_s[5];
        ext_irq[2]   = func_q[7] & pin_s[7];
        wake_req     = pin_s[7] & (func_q[7] | drv_en);
    end
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic [7:0] pad_in,
    input logic [7:0] pad_out,
    input logic [7:0] pad_oe,
    input logic [7:0] dir,
    input logic [7:0] func,
    input logic [7:0] open,
    input logic       drv_en,
    input logic [1:0] ser_rxd,
    input logic [1:0] tmr8_clk,
    input logic       wake_req
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    // R3: a pin with direction 0 never drives
    a_r3_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir) == 8'h00);

    // R4: open-drain pins only ever drive low
    a_r4_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        (open[0] & dir[0]) |-> (pad_out[0] == 1'b0));

    // R4: open-drain bits outside pins 0 and 2 never get set
    a_r4_od_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (open & 8'hFA) == 8'h00);

    // R2: read data holds without a read strobe
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R8 / R5: timer clock is the pad two edges back
    a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (tmr8_clk[0] == $past(pad_in[0], 2)));

    // R7: receive idles high unless pin 1 is a receive input
    a_r7_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(func[1] & ~dir[1]) |-> ser_rxd[0]);

    // R10: wake needs the function bit or the drive-enable control
    a_r10_wake_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!func[7] && !drv_en) |-> !wake_req);
endmodule

bind pinmux_port pinmux_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .dir      (dir_q),
    .func     (func_q),
    .open     (open_q),
    .drv_en   (drv_en),
    .ser_rxd  (ser_rxd),
    .tmr8_clk (tmr8_clk),
    .wake_req (wake_req)
);

// File: tb/pinmux_port_tb.sv
`timescale 1ns/1ps
module pinmux_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pad_in = '0, pad_out, pad_oe;
    logic [1:0] ser_txd = '0, tmr8_out = '0;
    logic       tmr16_ff = 1'b0, drv_en = 1'b0;
    logic [1:0] ser_rxd, tmr8_clk, tmr16_clk;
    logic [2:0] ext_irq;
    logic       wake_req;

    int checks = 0, errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pinmux_port u_dut (.*);

    // behavioural reference state
    logic [7:0] m_lat, m_dir, m_fn, m_od, m_rd;
    logic [7:0] m_hist [$];

    function automatic logic [7:0] m_pin();
        return m_hist[1];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lat = 8'hFF; m_dir = 8'h00; m_fn = 8'h00; m_od = 8'h00; m_rd = 8'h00;
            m_hist = {8'h00, 8'h00};
        end else begin
            if (bus_rd) begin
                case (bus_addr)
                    2'd0: m_rd = (m_lat & m_dir) | (m_pin() & ~m_dir);
                    2'd1: m_rd = m_dir;
                    2'd2: m_rd = m_fn;
                    default: m_rd = m_od;
                endcase
            end
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: m_lat = bus_wdata;
                    2'd1: m_dir = bus_wdata;
                    2'd2: m_fn  = bus_wdata;
                    default: m_od = bus_wdata & 8'h05;
                endcase
            end
            m_hist.push_front(pad_in);
            void'(m_hist.pop_back());
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [7:0] p, eo, ee, alt;
            logic [1:0] rx;
            p = m_pin();
            alt = 8'h00;
            alt[0] = ser_txd[0]; alt[2] = ser_txd[1];
            alt[1] = tmr8_out[0]; alt[3] = tmr8_out[1]; alt[6] = tmr16_ff;
            for (int i = 0; i < 8; i++) begin
                logic s;
                s = (m_fn[i] && (i <= 3 || i == 6)) ? alt[i] : m_lat[i];
                if (m_od[i] && m_dir[i]) begin eo[i] = 1'b0; ee[i] = ~s; end
                else begin eo[i] = s; ee[i] = m_dir[i]; end
            end
            rx[0] = (m_fn[1] && !m_dir[1]) ? p[1] : 1'b1;
            rx[1] = (m_fn[3] && !m_dir[3]) ? p[3] : 1'b1;
            chk("R3 R4 pad_out", pad_out, eo);
            chk("R3 R4 pad_oe", pad_oe, ee);
            chk("R2 R6 rdata", bus_rdata, m_rd);
            chk("R7 rxd", {6'd0, ser_rxd}, {6'd0, rx});
            chk("R8 R5 tmr8_clk", {6'd0, tmr8_clk}, {6'd0, p[2], p[0]});
            chk("R9 tmr16_clk", {6'd0, tmr16_clk}, {6'd0, p[5] & m_fn[5], p[4] & m_fn[4]});
            chk("R9 R10 ext_irq", {5'd0, ext_irq},
                {5'd0, p[7] & m_fn[7], p[5] & m_fn[5], p[4] & m_fn[4]});
            chk("R10 wake", {7'd0, wake_req}, {7'd0, p[7] & (m_fn[7] | drv_en)});
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic bus_op(bit w, bit r, logic [1:0] a, logic [7:0] d);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rd_expect(string req, logic [1:0] a, logic [7:0] exp);
        bus_op(1'b0, 1'b1, a, 8'h00);
        @(negedge clk);
        chk(req, bus_rdata, exp);
        step();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        chk_on = 1'b1;
        @(negedge clk);
        // R1: reset values seen at the pins
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'hFF);
        step();
        rd_expect("R1 dir", 2'd1, 8'h00);
        rd_expect("R1 func", 2'd2, 8'h00);
        rd_expect("R1 open", 2'd3, 8'h00);
        // R4: only bits 0 and 2 stick
        bus_op(1'b1, 1'b0, 2'd3, 8'hFF);
        rd_expect("R4 open mask", 2'd3, 8'h05);
        // R6: mixed read of latch and pins
        bus_op(1'b1, 1'b0, 2'd0, 8'hA5);
        bus_op(1'b1, 1'b0, 2'd1, 8'h0F);
        pad_in = 8'h3C;
        step(); step();
        rd_expect("R6 mixed read", 2'd0, 8'h35);
        // R10: pin 7 wake gating
        bus_op(1'b1, 1'b0, 2'd2, 8'h00);
        pad_in = 8'h80; drv_en = 1'b0;
        step(); step();
        @(negedge clk);
        chk("R10 wake blocked", {7'd0, wake_req}, 8'h00);
        step();
        drv_en = 1'b1;
        @(negedge clk);
        chk("R10 wake via drv_en", {7'd0, wake_req}, 8'h01);
        step();
        // randomized phase, model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            pad_in   = r[7:0];
            ser_txd  = r[9:8];
            tmr8_out = r[11:10];
            tmr16_ff = r[12];
            drv_en   = r[13];
            bus_addr = r[15:14];
            bus_wr   = (r[18:16] == 3'd0);
            bus_rd   = (r[21:19] < 3'd3);
            bus_wdata = r[29:22];
            step();
        end
        bus_wr = 1'b0; bus_rd = 1'b0;
        step();
        finish_run();
    end
endmodule